// File: doc/BRIEF.md
# Instruction Prefetch Queue with Holding Buffer

This block is the front end of a processor's instruction fetch path. It holds a short queue of fetched program words: a head stage that the decoder reads and a refill stage behind it. It also has a single holding buffer. That buffer parks a word that arrives from the bus while the execution unit is not yet ready to advance the queue.

On every clock the block looks at two inputs: the bus-data-valid strobe and the advance request. It then chooses one of four data movements and reports that choice on a two-bit status output. An advance shifts the queue by one word. The refill stage is loaded from the holding buffer when the buffer holds a word, and from the bus otherwise. Bus data that arrives without an advance is parked in the buffer. All outputs are registered, so the effect of the inputs sampled at a clock edge appears on the outputs right after that edge.

Top module: `prefetch_queue`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs show `head_vld`=0, `head_data`=0, `stg1_vld`=0, `stg1_data`=0 and `move_code`=2'b00. The holding buffer is also emptied, so an advance made right after reset with no bus data leaves `stg1_vld`=0 and reports 2'b10.
- R2: A cycle with `adv`=0 and `bus_vld`=0 reports `move_code`=2'b00 and leaves both stages unchanged.
- R3: A cycle with `adv`=0 and `bus_vld`=1 reports `move_code`=2'b01 (latch) and leaves both stages unchanged. If the buffer is empty, the bus word is stored in it.
- R4: While the buffer is full, further latch cycles (`adv`=0, `bus_vld`=1) still report 2'b01, but their bus words are ignored. The first parked word is the one a later advance delivers.
- R5: On a cycle with `adv`=1, the head stage takes the previous refill-stage word and its valid flag.
- R6: On an advance with the buffer empty, `move_code`=2'b10. The refill stage takes `bus_data`, and its valid flag is set to `bus_vld`, so an advance with no data leaves the stage invalid.
- R7: On an advance with the buffer full, `move_code`=2'b11. The refill stage takes the parked word and becomes valid, and the buffer is emptied unless R8 applies.
- R8: On an advance with the buffer full and `bus_vld`=1 in the same cycle, the bus word is parked in the buffer that has just been freed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_vld | input | 1 | A fetched word is present on `bus_data` |
| bus_data | input | 16 | Fetched program word |
| adv | input | 1 | Execution unit requests a one-word advance |
| head_data | output | 16 | Word at the head of the queue |
| head_vld | output | 1 | Head word is valid |
| stg1_data | output | 16 | Word in the refill stage |
| stg1_vld | output | 1 | Refill-stage word is valid |
| move_code | output | 2 | Data movement of the last cycle: 00 none, 01 latch, 10 advance from bus, 11 advance from buffer |

## Verification
On every cycle, the assertions check the shift from the refill stage into the head, the choice of refill source and its status code, the quiet-cycle code, and that the parked word stays stable while the buffer is full. Some behaviour only the bench's scenarios can show. One case is that an ignored latch really loses its word: this appears several cycles later, when the first parked word comes out. Others are a buffer being reloaded in the same cycle it is drained, and a reset that empties a full buffer, which shows only on the advance after it.

// File: rtl/pq_pkg.sv
// Package: shared encodings for the prefetch queue.
// Assumes: the status code values are fixed by the requirements and are
// decoded by neighbouring logic, so they must not be renumbered.
package pq_pkg;
    typedef enum logic [1:0] {
        MV_NONE    = 2'b00,
        MV_LATCH   = 2'b01,
        MV_ADV_BUS = 2'b10,
        MV_ADV_BUF = 2'b11
    } move_t;
endpackage

// File: rtl/pq_ctrl.sv
// Module: pq_ctrl
// Purely combinational decision logic. It chooses this cycle's data movement
// from the advance request, the bus strobe and the buffer state.
// Assumes: the buffer state comes from pq_hold_buf in the same cycle.
module pq_ctrl
    import pq_pkg::*;
(
    input  logic  adv,
    input  logic  bus_vld,
    input  logic  buf_vld,
    output logic  use_buf,
    output logic  buf_load,
    output logic  buf_clr,
    output move_t move
);
    // Choose the refill source, the buffer action and the status code.
    always_comb begin
        use_buf  = 1'b0;
        buf_load = 1'b0;
        buf_clr  = 1'b0;
        move     = MV_NONE;
        if (adv) begin
            if (buf_vld) begin
                use_buf  = 1'b1;
                move     = MV_ADV_BUF;
                buf_clr  = !bus_vld;
                buf_load = bus_vld;
            end else begin
                move     = MV_ADV_BUS;
            end
        end else if (bus_vld) begin
            move     = MV_LATCH;
            buf_load = !buf_vld;
        end
    end
endmodule

// File: rtl/pq_hold_buf.sv
// Module: pq_hold_buf
// A one-word holding register with a valid flag. A load takes priority
// over a clear.
// Assumes: the control logic never loads over a word that nobody consumes.
module pq_hold_buf #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         clr,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         vld
);
    // Hold the parked word and track whether it is present.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout <= '0;
            vld  <= 1'b0;
        end else if (load) begin
            dout <= din;
            vld  <= 1'b1;
        end else if (clr) begin
            vld  <= 1'b0;
        end
    end

    // R4
    full_word_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (vld && !load) |=> $stable(dout));

    // R3
    load_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (vld && dout == $past(din)));
endmodule

// File: rtl/pq_stages.sv
// Module: pq_stages
// A shift chain of DEPTH word stages. Stage 0 is the head. The last stage
// is loaded from the refill path on an advance.
// Assumes: DEPTH is at least 2.
module pq_stages #(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         adv,
    input  logic [W-1:0] fill_data,
    input  logic         fill_vld,
    output logic [W-1:0] st_data [DEPTH],
    output logic         st_vld  [DEPTH]
);
    localparam int LAST = DEPTH - 1;

    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
        logic [W-1:0] nxt_d;
        logic         nxt_v;
        if (i == LAST) begin : g_tail
            assign nxt_d = fill_data;
            assign nxt_v = fill_vld;
        end else begin : g_body
            assign nxt_d = st_data[i+1];
            assign nxt_v = st_vld[i+1];
        end
        // Shift one word toward the head on an advance.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_data[i] <= '0;
                st_vld[i]  <= 1'b0;
            end else if (adv) begin
                st_data[i] <= nxt_d;
                st_vld[i]  <= nxt_v;
            end
        end
    end

    // R5
    head_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        adv |=> (st_data[0] == $past(st_data[1]) && st_vld[0] == $past(st_vld[1])));

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> ($stable(st_data[0]) && $stable(st_vld[0])
                  && $stable(st_data[LAST]) && $stable(st_vld[LAST])));
endmodule

// File: rtl/prefetch_queue.sv
// Module: prefetch_queue (top)
// A two-stage instruction prefetch queue with a one-word holding buffer and
// a registered data-movement status code.
// Assumes: bus_data is only meaningful while bus_vld is high.
module prefetch_queue
    import pq_pkg::*;
#(
    parameter int W     = 16,
    parameter int DEPTH = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_vld,
    input  logic [W-1:0] bus_data,
    input  logic         adv,
    output logic [W-1:0] head_data,
    output logic         head_vld,
    output logic [W-1:0] stg1_data,
    output logic         stg1_vld,
    output logic [1:0]   move_code
);
    localparam int LAST = DEPTH - 1;

    logic         use_buf, buf_load, buf_clr, buf_vld;
    logic [W-1:0] buf_data;
    move_t        move, move_q;
    logic [W-1:0] fill_data;
    logic         fill_vld;
    logic [W-1:0] st_data [DEPTH];
    logic         st_vld  [DEPTH];

    pq_ctrl u_ctrl (
        .adv      (adv),
        .bus_vld  (bus_vld),
        .buf_vld  (buf_vld),
        .use_buf  (use_buf),
        .buf_load (buf_load),
        .buf_clr  (buf_clr),
        .move     (move)
    );

    pq_hold_buf #(.W(W)) u_buf (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (buf_load),
        .clr   (buf_clr),
        .din   (bus_data),
        .dout  (buf_data),
        .vld   (buf_vld)
    );

    // Pick the refill word: the buffer first, otherwise the bus.
    always_comb begin
        fill_data = use_buf ? buf_data : bus_data;
        fill_vld  = use_buf ? 1'b1     : bus_vld;
    end

    pq_stages #(.W(W), .DEPTH(DEPTH)) u_stages (
        .clk       (clk),
        .rst_n     (rst_n),
        .adv       (adv),
        .fill_data (fill_data),
        .fill_vld  (fill_vld),
        .st_data   (st_data),
        .st_vld    (st_vld)
    );

    // Register the status code so it lines up with the updated stages.
    always_ff @(posedge clk) begin
        if (!rst_n) move_q <= MV_NONE;
        else        move_q <= move;
    end

    assign head_data = st_data[0];
    assign head_vld  = st_vld[0];
    assign stg1_data = st_data[LAST];
    assign stg1_vld  = st_vld[LAST];
    assign move_code = move_q;

    // R1
    reset_state_chk: assert property (@(posedge clk)
        !rst_n |=> (move_code == 2'b00 && !head_vld && !stg1_vld));

    // R7
    adv_from_buf_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && buf_vld) |=> (move_code == 2'b11 && stg1_vld
                              && stg1_data == $past(buf_data)));

    // R6
    adv_from_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (adv && !buf_vld) |=> (move_code == 2'b10 && stg1_vld == $past(bus_vld)
                               && stg1_data == $past(bus_data)));

    // R3
    latch_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && bus_vld) |=> (move_code == 2'b01 && buf_vld));

    // R2
    idle_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!adv && !bus_vld) |=> move_code == 2'b00);
endmodule

// File: tb/tb_prefetch_queue.sv
module tb_prefetch_queue;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_vld = 1'b0;
    logic [15:0] bus_data = '0;
    logic        adv = 1'b0;
    logic [15:0] head_data, stg1_data;
    logic        head_vld, stg1_vld;
    logic [1:0]  move_code;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    prefetch_queue dut (
        .clk(clk), .rst_n(rst_n), .bus_vld(bus_vld), .bus_data(bus_data),
        .adv(adv), .head_data(head_data), .head_vld(head_vld),
        .stg1_data(stg1_data), .stg1_vld(stg1_vld), .move_code(move_code)
    );

    typedef struct packed {
        logic        adv;
        logic        vld;
        logic [15:0] d;
        logic        hv;
        logic [15:0] hd;
        logic        sv;
        logic [15:0] sd;
        logic [1:0]  code;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b1, 16'hA1A1, 1'b0, 16'h0000, 1'b0, 16'h0000, 2'b01}, // R3 latch
        '{1'b0, 1'b1, 16'hB2B2, 1'b0, 16'h0000, 1'b0, 16'h0000, 2'b01}, // R4 ignored
        '{1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b1, 16'hA1A1, 2'b11}, // R7 R4
        '{1'b1, 1'b1, 16'hC3C3, 1'b1, 16'hA1A1, 1'b1, 16'hC3C3, 2'b10}, // R6 R5
        '{1'b0, 1'b0, 16'h0000, 1'b1, 16'hA1A1, 1'b1, 16'hC3C3, 2'b00}, // R2
        '{1'b0, 1'b1, 16'hD4D4, 1'b1, 16'hA1A1, 1'b1, 16'hC3C3, 2'b01}, // R3
        '{1'b1, 1'b1, 16'hE5E5, 1'b1, 16'hC3C3, 1'b1, 16'hD4D4, 2'b11}, // R8
        '{1'b1, 1'b0, 16'h0000, 1'b1, 16'hD4D4, 1'b1, 16'hE5E5, 2'b11}, // R8 R7
        '{1'b1, 1'b0, 16'h0000, 1'b1, 16'hE5E5, 1'b0, 16'h0000, 2'b10}, // R6 empty
        '{1'b1, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 2'b10}, // R5 invalid
        '{1'b0, 1'b0, 16'h0000, 1'b0, 16'h0000, 1'b0, 16'h0000, 2'b00}, // R2
        '{1'b1, 1'b1, 16'hF6F6, 1'b0, 16'h0000, 1'b1, 16'hF6F6, 2'b10}  // R6
    };

    task automatic check(input string req, input logic [51:0] act, input logic [51:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [51:0] outs();
        return {head_vld, head_data, stg1_vld, stg1_data, move_code};
    endfunction

    initial begin : watchdog
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1", outs(), 52'h0);
        rst_n = 1'b1;
        for (int i = 0; i < NV; i++) begin
            adv = TBL[i].adv; bus_vld = TBL[i].vld; bus_data = TBL[i].d;
            @(negedge clk);
            check($sformatf("vector %0d", i), outs(),
                  {TBL[i].hv, TBL[i].hd, TBL[i].sv, TBL[i].sd, TBL[i].code});
        end
        // R1: reset with a full buffer empties it
        adv = 1'b0; bus_vld = 1'b1; bus_data = 16'h7777;
        @(negedge clk);
        check("R3 park before reset", {50'h0, move_code}, {50'h0, 2'b01});
        rst_n = 1'b0; bus_vld = 1'b0; bus_data = 16'h0000;
        @(negedge clk);
        check("R1 mid-run reset", outs(), 52'h0);
        rst_n = 1'b1; adv = 1'b1;
        @(negedge clk);
        check("R1 buffer empty after reset", outs(), {1'b0, 16'h0, 1'b0, 16'h0, 2'b10});
        adv = 1'b0;
        @(negedge clk);
        check("R2 idle after reset", {50'h0, move_code}, {50'h0, 2'b00});
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule